// File: doc/BRIEF.md
# Memory Type Range Resolver

This block maps a physical address onto a caching type. Software programs a small bank of variable ranges, each a 4 KB aligned base and mask, plus a type code and an enable bit. A separate default register supplies the type used when no range claims the address. For every lookup the block finds all enabled ranges that cover the address. It folds their types into one result using fixed overlap rules, and decodes that result into the attribute flags the load/store path needs.

Overlaps are never settled by range order. Uncacheable dominates any mix, and write-through wins over write-back. Every other mix of two or more distinct types is reported as undefined, and the uncacheable type is returned as a safe fallback. Writes go through a small address/data/enable port and take effect at the next clock edge. The lookup path is purely combinational from the stored state.

Top module: `mtr_resolver`

## Requirements
- R1: After reset every range is disabled and the default register holds type 0 with its enable clear, so every lookup returns type 0 with the undefined flag low.
- R2: Write address `{index, field}`: field 0 writes the base and field 1 writes the mask of range `index`, keeping bits 35..12 of the data. An enabled range covers an address when `(addr & mask) == (base & mask)` over bits 35..12. Address bits 11..0 and base bits 11..0 play no part.
- R3: Field 2 writes a range's control, with data bits 7..0 as the type and bit 8 as the enable. Field 3 writes the default register (any index), with bits 7..0 as the type and bit 8 as the default enable. A control or default write whose type is 2, 3 or 7..255 is rejected, and the previous contents stay unchanged.
- R4: When no enabled range covers the address, the result is the default type if the default enable is set, and type 0 otherwise.
- R5: When all covering ranges carry one type, that type is the result and the undefined flag is low.
- R6: When any covering range is uncacheable (0), the result is 0 with the undefined flag low.
- R7: When the covering types are exactly write-through (4) and write-back (6), the result is 4.
- R8: Any other mix of two or more distinct covering types raises the undefined flag and returns 0. The flag is low in all other cases.
- R9: Attributes as {cache_rd, cache_wr, wb_ok, spec_rd, order} (order 0 strong, 1 weak, 2 speculative) are: 0 → {0,0,0,0,0}; 1 (write-combining) → {0,0,0,1,1}; 4 → {1,1,0,1,2}; 5 (write-protected) → {1,0,0,1,2}; 6 → {1,1,1,1,2}.
- R10: A write changes lookups only after the clock edge that captures it. Lookups reflect the stored state without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | {range index, field} |
| wr_data | input | 36 | Write data |
| lk_addr | input | 36 | Physical address to classify |
| res_type | output | 8 | Resolved type code |
| undef_ovl | output | 1 | Undefined overlap detected |
| cache_rd | output | 1 | Reads may be cached |
| cache_wr | output | 1 | Writes may be cached |
| wb_ok | output | 1 | Write-back permitted |
| spec_rd | output | 1 | Speculative reads permitted |
| order | output | 2 | Ordering model: 0 strong, 1 weak, 2 speculative |

## Verification
Three nested ranges of 1 MB, 64 KB and 4 KB share one corner. A single lookup address therefore hits two or three of them. The bench sweeps every ordered pair and triple of the five legal types across those ranges, which separates the same-type, uncacheable-dominant, write-through-over-write-back and undefined cases. Further lookups outside the nest, inside only the smallest range, and in the highest-indexed range distinguish the mask compare, the ignored low bits and the default path. Reserved-code writes and a lookup taken before the capturing edge confirm the rejection rule and the write timing.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int TYPE_W = 8;

    localparam logic [TYPE_W-1:0] MT_UC = 8'd0;
    localparam logic [TYPE_W-1:0] MT_WC = 8'd1;
    localparam logic [TYPE_W-1:0] MT_WT = 8'd4;
    localparam logic [TYPE_W-1:0] MT_WP = 8'd5;
    localparam logic [TYPE_W-1:0] MT_WB = 8'd6;

    // one-hot slots of the "types seen" vector
    localparam int SEEN_W  = 5;
    localparam int S_UC = 0;
    localparam int S_WC = 1;
    localparam int S_WT = 2;
    localparam int S_WP = 3;
    localparam int S_WB = 4;

    localparam logic [1:0] ORD_STRONG = 2'd0;
    localparam logic [1:0] ORD_WEAK   = 2'd1;
    localparam logic [1:0] ORD_SPEC   = 2'd2;

    typedef struct packed {
        logic       cache_rd;
        logic       cache_wr;
        logic       wb_ok;
        logic       spec_rd;
        logic [1:0] order;
    } attr_t;

    function automatic logic code_ok(input logic [TYPE_W-1:0] c);
        return (c == MT_UC) || (c == MT_WC) || (c == MT_WT) ||
               (c == MT_WP) || (c == MT_WB);
    endfunction

    function automatic logic [SEEN_W-1:0] code_slot(input logic [TYPE_W-1:0] c);
        logic [SEEN_W-1:0] s;
        s = '0;
        case (c)
            MT_UC:   s[S_UC] = 1'b1;
            MT_WC:   s[S_WC] = 1'b1;
            MT_WT:   s[S_WT] = 1'b1;
            MT_WP:   s[S_WP] = 1'b1;
            MT_WB:   s[S_WB] = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic [TYPE_W-1:0] slot_code(input logic [SEEN_W-1:0] s);
        logic [TYPE_W-1:0] c;
        c = MT_UC;
        if (s[S_WC]) c = MT_WC;
        if (s[S_WT]) c = MT_WT;
        if (s[S_WP]) c = MT_WP;
        if (s[S_WB]) c = MT_WB;
        return c;
    endfunction

endpackage

// File: rtl/mtr_range_file.sv
module mtr_range_file
    import mtr_pkg::*;
#(
    parameter  int NUM_RANGES = 8,
    parameter  int ADDR_W     = 36,
    parameter  int PG_SH      = 12,
    localparam int IDX_W      = $clog2(NUM_RANGES),
    localparam int PN_W       = ADDR_W - PG_SH
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W+1:0]                   wr_addr,
    input  logic [ADDR_W-1:0]                  wr_data,
    output logic [NUM_RANGES-1:0][PN_W-1:0]    base_o,
    output logic [NUM_RANGES-1:0][PN_W-1:0]    mask_o,
    output logic [NUM_RANGES-1:0][TYPE_W-1:0]  type_o,
    output logic [NUM_RANGES-1:0]              vld_o,
    output logic [TYPE_W-1:0]                  dflt_type_o,
    output logic                               dflt_en_o
);

    localparam logic [1:0] F_BASE = 2'd0;
    localparam logic [1:0] F_MASK = 2'd1;
    localparam logic [1:0] F_CTRL = 2'd2;
    localparam logic [1:0] F_DFLT = 2'd3;

    typedef struct packed {
        logic [NUM_RANGES-1:0][PN_W-1:0]   base;
        logic [NUM_RANGES-1:0][PN_W-1:0]   mask;
        logic [NUM_RANGES-1:0][TYPE_W-1:0] typ;
        logic [NUM_RANGES-1:0]             vld;
        logic [TYPE_W-1:0]                 dtyp;
        logic                              den;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [1:0]        fld;
    logic [IDX_W-1:0]  idx;
    logic [TYPE_W-1:0] wr_code;
    logic              wr_code_ok;

    assign fld        = wr_addr[1:0];
    assign idx        = wr_addr[IDX_W+1:2];
    assign wr_code    = wr_data[TYPE_W-1:0];
    assign wr_code_ok = code_ok(wr_code);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (fld)
                F_BASE: st_d.base[idx] = wr_data[ADDR_W-1:PG_SH];
                F_MASK: st_d.mask[idx] = wr_data[ADDR_W-1:PG_SH];
                F_CTRL: begin
                    if (wr_code_ok) begin
                        st_d.typ[idx] = wr_code;
                        st_d.vld[idx] = wr_data[TYPE_W];
                    end
                end
                default: begin
                    if (wr_code_ok) begin
                        st_d.dtyp = wr_code;
                        st_d.den  = wr_data[TYPE_W];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o      = st_q.base;
    assign mask_o      = st_q.mask;
    assign type_o      = st_q.typ;
    assign vld_o       = st_q.vld;
    assign dflt_type_o = st_q.dtyp;
    assign dflt_en_o   = st_q.den;

    // R3
    reserved_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == F_CTRL && !code_ok(wr_data[TYPE_W-1:0]))
        |=> ($stable(type_o) && $stable(vld_o)));

    // R3
    reserved_dflt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == F_DFLT && !code_ok(wr_data[TYPE_W-1:0]))
        |=> ($stable(dflt_type_o) && $stable(dflt_en_o)));

endmodule

// File: rtl/mtr_match.sv
module mtr_match
    import mtr_pkg::*;
#(
    parameter  int NUM_RANGES = 8,
    parameter  int ADDR_W     = 36,
    parameter  int PG_SH      = 12,
    localparam int PN_W       = ADDR_W - PG_SH
) (
    input  logic [ADDR_W-1:0]                 lk_addr,
    input  logic [NUM_RANGES-1:0][PN_W-1:0]   base_i,
    input  logic [NUM_RANGES-1:0][PN_W-1:0]   mask_i,
    input  logic [NUM_RANGES-1:0][TYPE_W-1:0] type_i,
    input  logic [NUM_RANGES-1:0]             vld_i,
    output logic [NUM_RANGES-1:0]             hit_o,
    output logic [SEEN_W-1:0]                 seen_o
);

    logic [PN_W-1:0] lk_page;
    assign lk_page = lk_addr[ADDR_W-1:PG_SH];

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        assign hit_o[g] = vld_i[g] &&
                          ((lk_page & mask_i[g]) == (base_i[g] & mask_i[g]));
    end

    always_comb begin
        seen_o = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (hit_o[i]) seen_o = seen_o | code_slot(type_i[i]);
        end
    end

endmodule

// File: rtl/mtr_merge.sv
module mtr_merge
    import mtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEEN_W-1:0] seen_i,
    input  logic [TYPE_W-1:0] dflt_type_i,
    input  logic              dflt_en_i,
    output logic [TYPE_W-1:0] res_o,
    output logic              undef_o,
    output attr_t             attr_o
);

    localparam logic [SEEN_W-1:0] WT_WB_ONLY = SEEN_W'((1 << S_WT) | (1 << S_WB));

    logic [2:0] n_seen;
    assign n_seen = 3'($countones(seen_i));

    always_comb begin
        res_o   = MT_UC;
        undef_o = 1'b0;
        if (n_seen == 3'd0) begin
            res_o = dflt_en_i ? dflt_type_i : MT_UC;
        end else if (n_seen == 3'd1) begin
            res_o = slot_code(seen_i);
        end else if (seen_i[S_UC]) begin
            res_o = MT_UC;
        end else if (seen_i == WT_WB_ONLY) begin
            res_o = MT_WT;
        end else begin
            undef_o = 1'b1;
        end
    end

    always_comb begin
        case (res_o)
            MT_WC:   attr_o = '{cache_rd: 1'b0, cache_wr: 1'b0, wb_ok: 1'b0, spec_rd: 1'b1, order: ORD_WEAK};
            MT_WT:   attr_o = '{cache_rd: 1'b1, cache_wr: 1'b1, wb_ok: 1'b0, spec_rd: 1'b1, order: ORD_SPEC};
            MT_WP:   attr_o = '{cache_rd: 1'b1, cache_wr: 1'b0, wb_ok: 1'b0, spec_rd: 1'b1, order: ORD_SPEC};
            MT_WB:   attr_o = '{cache_rd: 1'b1, cache_wr: 1'b1, wb_ok: 1'b1, spec_rd: 1'b1, order: ORD_SPEC};
            default: attr_o = '{cache_rd: 1'b0, cache_wr: 1'b0, wb_ok: 1'b0, spec_rd: 1'b0, order: ORD_STRONG};
        endcase
    end

    // R6
    uc_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_i[S_UC] |-> (res_o == MT_UC && !undef_o));

    // R7
    wt_over_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_i == WT_WB_ONLY) |-> (res_o == MT_WT && !undef_o));

    // R5
    single_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(seen_i) == 1) |-> !undef_o);

    // R8
    undef_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (res_o == MT_UC && $countones(seen_i) > 1));

    // R9
    wr_cache_implies_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_o.cache_wr || attr_o.wb_ok) |-> attr_o.cache_rd);

    // R9
    strong_no_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_o.order == ORD_STRONG) |-> (!attr_o.spec_rd && !attr_o.cache_rd));

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter  int NUM_RANGES = 8,
    parameter  int ADDR_W     = 36,
    parameter  int PG_SH      = 12,
    localparam int IDX_W      = $clog2(NUM_RANGES),
    localparam int PN_W       = ADDR_W - PG_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W+1:0]  wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [TYPE_W-1:0] res_type,
    output logic              undef_ovl,
    output logic              cache_rd,
    output logic              cache_wr,
    output logic              wb_ok,
    output logic              spec_rd,
    output logic [1:0]        order
);

    logic [NUM_RANGES-1:0][PN_W-1:0]   base_w;
    logic [NUM_RANGES-1:0][PN_W-1:0]   mask_w;
    logic [NUM_RANGES-1:0][TYPE_W-1:0] type_w;
    logic [NUM_RANGES-1:0]             vld_w;
    logic [NUM_RANGES-1:0]             hit_w;
    logic [TYPE_W-1:0]                 dtyp_w;
    logic                              den_w;
    logic [SEEN_W-1:0]                 seen_w;
    attr_t                             attr_w;

    mtr_range_file #(
        .NUM_RANGES (NUM_RANGES),
        .ADDR_W     (ADDR_W),
        .PG_SH      (PG_SH)
    ) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .base_o      (base_w),
        .mask_o      (mask_w),
        .type_o      (type_w),
        .vld_o       (vld_w),
        .dflt_type_o (dtyp_w),
        .dflt_en_o   (den_w)
    );

    mtr_match #(
        .NUM_RANGES (NUM_RANGES),
        .ADDR_W     (ADDR_W),
        .PG_SH      (PG_SH)
    ) u_match (
        .lk_addr (lk_addr),
        .base_i  (base_w),
        .mask_i  (mask_w),
        .type_i  (type_w),
        .vld_i   (vld_w),
        .hit_o   (hit_w),
        .seen_o  (seen_w)
    );

    mtr_merge u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .seen_i      (seen_w),
        .dflt_type_i (dtyp_w),
        .dflt_en_i   (den_w),
        .res_o       (res_type),
        .undef_o     (undef_ovl),
        .attr_o      (attr_w)
    );

    assign cache_rd = attr_w.cache_rd;
    assign cache_wr = attr_w.cache_wr;
    assign wb_ok    = attr_w.wb_ok;
    assign spec_rd  = attr_w.spec_rd;
    assign order    = attr_w.order;

    // R2
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_w == '0) && !undef_ovl) |-> (res_type == (den_w ? dtyp_w : MT_UC)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (res_type == MT_UC && !undef_ovl && vld_w == '0));

endmodule

// File: tb/mtr_resolver_bench.sv
module mtr_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic [35:0] lk_addr = '0;
    logic [7:0]  res_type;
    logic        undef_ovl, cache_rd, cache_wr, wb_ok, spec_rd;
    logic [1:0]  order;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mtr_resolver u_mtr_resolver (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .lk_addr (lk_addr), .res_type (res_type),
        .undef_ovl (undef_ovl), .cache_rd (cache_rd), .cache_wr (cache_wr),
        .wb_ok (wb_ok), .spec_rd (spec_rd), .order (order)
    );

    localparam logic [35:0] NEST   = 36'h0_0010_0010;
    localparam logic [35:0] AWAY   = 36'h0_0020_0000;
    localparam logic [35:0] HIGH   = 36'h8_0000_0123;

    // R9 attribute table {cache_rd, cache_wr, wb_ok, spec_rd, order}
    function automatic logic [5:0] attr_of(input logic [7:0] t);
        case (t)
            8'd1:    return {4'b0001, 2'd1};
            8'd4:    return {4'b1101, 2'd2};
            8'd5:    return {4'b1001, 2'd2};
            8'd6:    return {4'b1111, 2'd2};
            default: return {4'b0000, 2'd0};
        endcase
    endfunction

    // returns {undef, type, attrs}
    function automatic logic [14:0] model(input int n, input logic [7:0] t0,
                                          input logic [7:0] t1, input logic [7:0] t2,
                                          input logic den, input logic [7:0] dt);
        logic [7:0] m;
        logic [7:0] r;
        logic       u;
        m = '0; u = 1'b0; r = 8'd0;
        if (n > 0) m[t0[2:0]] = 1'b1;
        if (n > 1) m[t1[2:0]] = 1'b1;
        if (n > 2) m[t2[2:0]] = 1'b1;
        if (n == 0)                  r = den ? dt : 8'd0;
        else if ($countones(m) == 1) r = t0;
        else if (m[0])               r = 8'd0;
        else if (m == 8'b0101_0000)  r = 8'd4;
        else                         u = 1'b1;
        return {u, r, attr_of(r)};
    endfunction

    task automatic put(input logic [4:0] a, input logic [35:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [35:0] a, input logic [14:0] exp);
        logic [14:0] got;
        lk_addr = a;
        #1;
        got = {undef_ovl, res_type, cache_rd, cache_wr, wb_ok, spec_rd, order};
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h exp=%h", req, a, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] legal [5];
        legal = '{8'd0, 8'd1, 8'd4, 8'd5, 8'd6};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        look("R1", NEST, model(0, 0, 0, 0, 1'b0, 8'd0));

        // geometry: nested 1 MB / 64 KB / 4 KB ranges at 0x100000
        put(5'd0, 36'h0_0010_0000); put(5'd1, 36'hF_FFF0_0000);
        put(5'd4, 36'h0_0010_0000); put(5'd5, 36'hF_FFFF_0000);
        put(5'd8, 36'h0_0010_0FFF); put(5'd9, 36'hF_FFFF_F000);

        // R10 write visible only after the capturing edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd2; wr_data = 36'h106;
        look("R10", NEST, model(0, 0, 0, 0, 1'b0, 8'd0));
        @(negedge clk);
        wr_en = 1'b0;
        look("R10", NEST, model(1, 8'd6, 0, 0, 1'b0, 8'd0));

        // R2 / R4 miss, default disabled then enabled
        look("R2", AWAY, model(0, 0, 0, 0, 1'b0, 8'd0));
        put(5'd3, 36'h101);
        look("R4", AWAY, model(0, 0, 0, 0, 1'b1, 8'd1));
        put(5'd3, 36'h006);
        look("R4", AWAY, model(0, 0, 0, 0, 1'b0, 8'd6));

        // R3 reserved codes rejected for ranges and default
        put(5'd2, 36'h102);
        look("R3", NEST, model(1, 8'd6, 0, 0, 1'b0, 8'd0));
        put(5'd2, 36'h0FF);
        look("R3", NEST, model(1, 8'd6, 0, 0, 1'b0, 8'd0));
        put(5'd3, 36'h107);
        look("R3", AWAY, model(0, 0, 0, 0, 1'b0, 8'd0));
        put(5'd3, 36'h103);
        look("R3", AWAY, model(0, 0, 0, 0, 1'b0, 8'd0));
        put(5'd3, 36'h105);
        look("R4", AWAY, model(0, 0, 0, 0, 1'b1, 8'd5));
        put(5'd3, 36'h000);

        // R2 smallest range only, base low bits ignored
        put(5'd2, 36'h006 & 36'h0FF);
        put(5'd10, 36'h105);
        look("R2", 36'h0_0010_0ABC, model(1, 8'd5, 0, 0, 1'b0, 8'd0));
        look("R2", 36'h0_0010_1000, model(0, 0, 0, 0, 1'b0, 8'd0));
        put(5'd10, 36'h005);

        // R2 highest range index
        put(5'd28, 36'h8_0000_0000); put(5'd29, 36'h8_0000_0000);
        put(5'd30, 36'h101);
        look("R2", HIGH, model(1, 8'd1, 0, 0, 1'b0, 8'd0));
        put(5'd30, 36'h001);
        look("R2", HIGH, model(0, 0, 0, 0, 1'b0, 8'd0));

        // R5 R6 R7 R8 R9 every ordered pair
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                put(5'd2, {28'h0, legal[a]} | 36'h100);
                put(5'd6, {28'h0, legal[b]} | 36'h100);
                look("R5-pair R6 R7 R8 R9", NEST,
                     model(2, legal[a], legal[b], 0, 1'b0, 8'd0));
            end
        end

        // R5 R6 R7 R8 R9 every ordered triple
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                for (int c = 0; c < 5; c++) begin
                    put(5'd2,  {28'h0, legal[a]} | 36'h100);
                    put(5'd6,  {28'h0, legal[b]} | 36'h100);
                    put(5'd10, {28'h0, legal[c]} | 36'h100);
                    look("R5-triple R6 R7 R8 R9", NEST,
                         model(3, legal[a], legal[b], legal[c], 1'b0, 8'd0));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule